// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on behalf of the processor, one unit per request. Each unit takes one read cycle and one write cycle, borrowed from the processor's bus. There are two channels. Each has a source pointer and a destination pointer in a 20-bit address space, and at most one of the two may step forward after every unit. Each channel also has a 16-bit transfer counter backed by a reload value. The transfer width is 8 or 16 bits, chosen per channel. Each channel runs in single mode or repeat mode.

Software sets a channel up through a small register bus and then enables it. A request for a channel comes from one of three places: a software strobe, an edge on the channel's external pin, or the rising edge of one of several peripheral request lines. When both channels have work at the same time, channel 0 goes first. When a channel's counter runs out, the channel raises a one-cycle interrupt pulse. In single mode the channel then switches itself off. In repeat mode it re-arms for a fresh run.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, every channel control register reads 0, the memory port makes no request and both interrupt outputs are low.
- R2: Register map. Address bit 3 selects the channel and bits 2:0 select the register: 0 control, 1 source, 2 destination, 3 reload, 4 live counter (read only). Control bits are: 0 enable, 1 repeat, 2 wide (16-bit), 3 source steps, 4 destination steps, 5 both pin edges, 11:8 trigger select, 15 software request strobe (always reads 0). A control write that sets both step bits keeps the source step bit and clears the destination step bit.
- R3: While a channel is enabled, writes to its source or destination register are ignored if that pointer does not step. A stepping pointer register can be written at any time.
- R4: The first granted request after enabling copies the stepping pointer register into the working pointer and the reload value into the counter. A run moves reload+1 units. After each unit the working pointer advances by 1 (8-bit) or 2 (16-bit), wrapping at 20 bits.
- R5: Each unit is one read at the source address followed by one write of the read data to the destination address. Each phase holds until mem_ready_i is high. mem_wide_o gives the unit width, and an 8-bit unit carries its data in the low byte.
- R6: Single mode: when the unit that finishes at counter value 0 completes, the hardware clears the enable bit.
- R7: Repeat mode: at the same point the channel stays enabled, and the next request reloads both the counter and the working pointer.
- R8: The channel's irq_o bit pulses high for exactly one cycle each time its counter underflows.
- R9: When both channels have a request waiting while the port is idle, channel 0 is served first.
- R10: Trigger select: 0 means software strobe only; 1 means a falling edge on the channel's ext_i bit, or either edge when the both-edges bit is set; 2+k means a rising edge on req_i[k]. The software strobe works with any select value.
- R11: A request that arrives while the channel is busy is held and served afterwards. Requests merge into one held request. Clearing the enable bit drops a held request.
- R12: While a channel is enabled and has started its run, reading its stepping pointer register returns the working pointer. Otherwise the read returns the stored register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: channel in bit 3, register in bits 2:0 |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data (combinational) |
| ext_i | input | 2 | External request pin, one per channel |
| req_i | input | NREQ | Peripheral request lines |
| mem_req_o | output | 1 | Memory cycle active |
| mem_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_wide_o | output | 1 | 1 for a 16-bit unit, 0 for an 8-bit unit |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data |
| mem_ready_i | input | 1 | Ends the current memory phase |
| irq_o | output | 2 | Underflow pulse, one bit per channel |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. The arbiter grants at most one channel and always picks channel 0 when it is waiting. A read completion is followed by a write, and the address stays put while the port stalls. A fixed pointer never changes while its channel is enabled. The step bits are never both set. An underflow clears or keeps the enable bit according to the mode, and the interrupt is a single-cycle pulse. The bench scenarios cover what depends on whole runs: transfer counts, final addresses and data, pointer wrap, the live pointer read-back, the edge-select rules, the merging and dropping of held requests, and the pointer restart in repeat mode.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int NCH  = 2;
  localparam int SELW = 4;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SRC  = 3'd1;
  localparam logic [2:0] IDX_DST  = 3'd2;
  localparam logic [2:0] IDX_RLD  = 3'd3;
  localparam logic [2:0] IDX_CNT  = 3'd4;

  localparam int B_EN   = 0;
  localparam int B_RPT  = 1;
  localparam int B_WIDE = 2;
  localparam int B_SINC = 3;
  localparam int B_DINC = 4;
  localparam int B_BOTH = 5;
  localparam int B_SEL  = 8;
  localparam int B_SW   = 15;

  typedef enum logic [1:0] {MST_IDLE, MST_RD, MST_WR} mst_e;
endpackage

// File: rtl/dmac_trig.sv
`timescale 1ns/1ps
module dmac_trig
  import dmac_pkg::*;
#(
  parameter int NREQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_i,
  input  logic [NREQ-1:0] req_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            both_i,
  output logic            evt_o
);
  logic            ext_q;
  logic [NREQ-1:0] req_q;
  logic [NREQ-1:0] req_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= 1'b1;
      req_q <= '0;
    end else begin
      ext_q <= ext_i;
      req_q <= req_i;
    end
  end

  assign req_rise = req_i & ~req_q;

  always_comb begin
    evt_o = 1'b0;
    if (sel_i == SELW'(1)) begin
      evt_o = (ext_q & ~ext_i) | (both_i & ~ext_q & ext_i);
    end else begin
      for (int k = 0; k < NREQ; k++) begin
        if (sel_i == SELW'(k + 2)) evt_o = req_rise[k];
      end
    end
  end
endmodule

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [2:0]      idx_i,
  input  logic [AW-1:0]   wdata_i,
  input  logic            evt_i,
  input  logic            grant_i,
  input  logic            done_i,
  output logic [AW-1:0]   rdata_o,
  output logic            pend_o,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic            wide_o,
  output logic            irq_o,
  output logic [SELW-1:0] sel_o,
  output logic            both_o
);
  logic            en_q, rpt_q, wide_q, sinc_q, dinc_q, both_q;
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   src_q, dst_q, wptr_q;
  logic [CW-1:0]   rld_q, cnt_q;
  logic            first_q, pend_q, irq_q;
  logic            ctrl_wr;
  logic [AW-1:0]   step;

  assign ctrl_wr = wr_i && (idx_i == IDX_CTRL);
  assign step    = wide_q ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; rpt_q <= 1'b0; wide_q <= 1'b0;
      sinc_q <= 1'b0; dinc_q <= 1'b0; both_q <= 1'b0;
      sel_q <= '0; src_q <= '0; dst_q <= '0; wptr_q <= '0;
      rld_q <= '0; cnt_q <= '0;
      first_q <= 1'b1; pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (grant_i) begin
        pend_q <= 1'b0;
        if (first_q) begin
          wptr_q  <= sinc_q ? src_q : dst_q;
          cnt_q   <= rld_q;
          first_q <= 1'b0;
        end
      end
      if (evt_i && en_q) pend_q <= 1'b1;
      if (done_i) begin
        if (sinc_q || dinc_q) wptr_q <= wptr_q + step;
        if (cnt_q == '0) begin
          irq_q <= 1'b1;
          if (rpt_q) first_q <= 1'b1;
          else begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (wr_i) begin
        case (idx_i)
          IDX_CTRL: begin
            en_q   <= wdata_i[B_EN];
            rpt_q  <= wdata_i[B_RPT];
            wide_q <= wdata_i[B_WIDE];
            sinc_q <= wdata_i[B_SINC];
            dinc_q <= wdata_i[B_DINC] & ~wdata_i[B_SINC];
            both_q <= wdata_i[B_BOTH];
            sel_q  <= wdata_i[B_SEL +: SELW];
            if (wdata_i[B_EN] && !en_q) first_q <= 1'b1;
            if (!wdata_i[B_EN]) pend_q <= 1'b0;
            else if (wdata_i[B_SW]) pend_q <= 1'b1;
          end
          IDX_SRC: if (!en_q || sinc_q) src_q <= wdata_i;
          IDX_DST: if (!en_q || dinc_q) dst_q <= wdata_i;
          IDX_RLD: rld_q <= wdata_i[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      IDX_CTRL: begin
        rdata_o[B_EN]   = en_q;
        rdata_o[B_RPT]  = rpt_q;
        rdata_o[B_WIDE] = wide_q;
        rdata_o[B_SINC] = sinc_q;
        rdata_o[B_DINC] = dinc_q;
        rdata_o[B_BOTH] = both_q;
        rdata_o[B_SEL +: SELW] = sel_q;
      end
      IDX_SRC: rdata_o = (en_q && sinc_q && !first_q) ? wptr_q : src_q;
      IDX_DST: rdata_o = (en_q && dinc_q && !first_q) ? wptr_q : dst_q;
      IDX_RLD: rdata_o[CW-1:0] = rld_q;
      IDX_CNT: rdata_o[CW-1:0] = cnt_q;
      default: ;
    endcase
  end

  assign pend_o = pend_q;
  assign src_o  = (sinc_q && !first_q) ? wptr_q : src_q;
  assign dst_o  = (dinc_q && !first_q) ? wptr_q : dst_q;
  assign wide_o = wide_q;
  assign irq_o  = irq_q;
  assign sel_o  = sel_q;
  assign both_o = both_q;

  AST_ONE_STEPPING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sinc_q && dinc_q)); // R2
  AST_FIXED_SRC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !sinc_q) |=> $stable(src_q)); // R3
  AST_FIXED_DST_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !dinc_q) |=> $stable(dst_q)); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cnt_q == '0 && !rpt_q && !ctrl_wr) |=> !en_q); // R6
  AST_REPEAT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && en_q && cnt_q == '0 && rpt_q && !ctrl_wr) |=> en_q); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R8
endmodule

// File: rtl/dma2_ctrl.sv
`timescale 1ns/1ps
module dma2_ctrl
  import dmac_pkg::*;
#(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int NREQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [3:0]      reg_addr_i,
  input  logic [AW-1:0]   reg_wdata_i,
  output logic [AW-1:0]   reg_rdata_o,
  input  logic [1:0]      ext_i,
  input  logic [NREQ-1:0] req_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_wide_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ready_i,
  output logic [1:0]      irq_o
);
  logic [NCH-1:0]  pend, grant, done, wide, evt, both;
  logic [AW-1:0]   ch_src [NCH];
  logic [AW-1:0]   ch_dst [NCH];
  logic [AW-1:0]   ch_rd  [NCH];
  logic [SELW-1:0] sel    [NCH];

  mst_e          st_q;
  logic          cur_q, wide_q;
  logic [AW-1:0] src_a_q, dst_a_q;
  logic [DW-1:0] data_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmac_trig #(.NREQ(NREQ)) u_trig (
      .clk_i (clk_i), .rst_ni (rst_ni), .ext_i (ext_i[c]), .req_i (req_i),
      .sel_i (sel[c]), .both_i (both[c]), .evt_o (evt[c])
    );
    dmac_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .wr_i (reg_we_i && (reg_addr_i[3] == c[0])),
      .idx_i (reg_addr_i[2:0]), .wdata_i (reg_wdata_i),
      .evt_i (evt[c]), .grant_i (grant[c]), .done_i (done[c]),
      .rdata_o (ch_rd[c]), .pend_o (pend[c]), .src_o (ch_src[c]),
      .dst_o (ch_dst[c]), .wide_o (wide[c]), .irq_o (irq_o[c]),
      .sel_o (sel[c]), .both_o (both[c])
    );
  end

  // fixed priority: channel 0 wins
  always_comb begin
    grant = '0;
    if (st_q == MST_IDLE) begin
      if (pend[0])      grant = 2'b01;
      else if (pend[1]) grant = 2'b10;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= MST_IDLE; cur_q <= 1'b0; wide_q <= 1'b0;
      src_a_q <= '0; dst_a_q <= '0; data_q <= '0;
    end else begin
      case (st_q)
        MST_IDLE: if (grant != '0) begin
          cur_q   <= grant[1];
          src_a_q <= ch_src[grant[1]];
          dst_a_q <= ch_dst[grant[1]];
          wide_q  <= wide[grant[1]];
          st_q    <= MST_RD;
        end
        MST_RD: if (mem_ready_i) begin
          data_q <= mem_rdata_i;
          st_q   <= MST_WR;
        end
        MST_WR: if (mem_ready_i) st_q <= MST_IDLE;
        default: st_q <= MST_IDLE;
      endcase
    end
  end

  assign done        = (st_q == MST_WR && mem_ready_i) ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
  assign mem_req_o   = (st_q != MST_IDLE);
  assign mem_we_o    = (st_q == MST_WR);
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = (st_q == MST_WR) ? dst_a_q : src_a_q;
  assign mem_wdata_o = data_q;
  assign reg_rdata_o = ch_rd[reg_addr_i[3]];

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R9
  AST_CH0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[0] && !mem_req_o) |-> grant[0]); // R9
  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> $stable(mem_addr_o)); // R5
endmodule

// File: tb/dma2_ctrl_bench.sv
`timescale 1ns/1ps
module dma2_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NREQ = 8;
  localparam logic [19:0] C_EN = 20'h1, C_RPT = 20'h2, C_WIDE = 20'h4, C_SINC = 20'h8,
                          C_DINC = 20'h10, C_BOTH = 20'h20, C_SW = 20'h8000;
  // {src, dst, reload, wide, src_step, dst_step, channel}
  localparam logic [59:0] VEC [4] = '{
    {20'h01000, 20'h02000, 16'd2, 4'b0100},
    {20'h03000, 20'h04000, 16'd3, 4'b1011},
    {20'h05010, 20'h06020, 16'd0, 4'b1000},
    {20'hFFFFE, 20'h00010, 16'd1, 4'b1101}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0, reg_rdata;
  logic [1:0] ext = 2'b11;
  logic [NREQ-1:0] req = '0;
  logic mem_req, mem_we, mem_wide, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] irq;

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;
  logic clr_log = 1'b0;
  int wcount, irq0_cnt, irq1_cnt;
  logic [AW-1:0] wlog [16];
  logic [AW-1:0] last_raddr;
  logic [DW-1:0] last_wdata;
  logic last_wide;

  always #5 clk = ~clk;

  dma2_ctrl #(.AW(AW), .DW(DW), .CW(16), .NREQ(NREQ)) u_dma2_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ext_i(ext), .req_i(req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .irq_o(irq)
  );

  function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA55A;
  endfunction

  assign mem_rdata = mval(mem_addr);

  always @(posedge clk) begin
    if (clr_log) begin
      wcount <= 0; irq0_cnt <= 0; irq1_cnt <= 0;
    end else begin
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          wlog[wcount[3:0]] <= mem_addr;
          wcount <= wcount + 1;
          last_wdata <= mem_wdata;
          last_wide <= mem_wide;
        end else last_raddr <= mem_addr;
      end
      if (irq[0]) irq0_cnt <= irq0_cnt + 1;
      if (irq[1]) irq1_cnt <= irq1_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [19:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [19:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    clr_log = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); clr_log = 1'b0;

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl0", 32'(v), 0);
    rd(4'h8, v); chk("R1 ctrl1", 32'(v), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);

    // table of single-mode runs: R4 R5 R6 R8
    for (int i = 0; i < 4; i++) begin
      logic [19:0] s, d, ctl, step, ls, ld;
      logic [15:0] rl;
      logic [3:0] f;
      logic [3:0] base;
      int n;
      {s, d, rl, f} = VEC[i];
      base = f[0] ? 4'h8 : 4'h0;
      step = f[3] ? 20'd2 : 20'd1;
      n = int'(rl) + 1;
      ls = f[2] ? s + 20'(rl) * step : s;
      ld = f[1] ? d + 20'(rl) * step : d;
      ctl = C_EN | (f[3] ? C_WIDE : 20'h0) | (f[2] ? C_SINC : 20'h0) | (f[1] ? C_DINC : 20'h0);
      clear_log();
      wr(base | 4'h1, s); wr(base | 4'h2, d); wr(base | 4'h3, 20'(rl));
      wr(base, ctl);
      for (int t = 0; t < n; t++) begin
        wr(base, ctl | C_SW);
        idle(6);
      end
      chk("R4 unit count", 32'(wcount), 32'(n));
      chk("R5 last write addr", 32'(wlog[4'(n - 1)]), 32'(ld));
      chk("R5 last read addr", 32'(last_raddr), 32'(ls));
      chk("R5 data", 32'(last_wdata & (f[3] ? 16'hFFFF : 16'h00FF)),
          32'(mval(ls) & (f[3] ? 16'hFFFF : 16'h00FF)));
      chk("R5 width", 32'(last_wide), 32'(f[3]));
      chk("R8 irq count", 32'(f[0] ? irq1_cnt : irq0_cnt), 1);
      rd(base, v); chk("R6 enable cleared", 32'(v[0]), 0);
    end

    // R2 both step bits
    wr(4'h0, C_SINC | C_DINC);
    rd(4'h0, v); chk("R2 step bits", 32'(v & 20'h18), 32'h08);
    wr(4'h0, 20'h0);

    // R3 / R12 write protection and live pointer
    wr(4'h9, 20'h00100); wr(4'hA, 20'h00200); wr(4'hB, 20'd5);
    wr(4'h8, C_EN | C_DINC | C_WIDE);
    wr(4'h9, 20'h00111);
    rd(4'h9, v); chk("R3 fixed src locked", 32'(v), 32'h00100);
    wr(4'hA, 20'h00300);
    rd(4'hA, v); chk("R3 stepping dst writable", 32'(v), 32'h00300);
    wr(4'h8, C_EN | C_DINC | C_WIDE | C_SW); idle(6);
    rd(4'hA, v); chk("R12 live pointer", 32'(v), 32'h00302);
    rd(4'hC, v); chk("R4 counter", 32'(v), 32'd4);
    wr(4'h8, 20'h0);
    rd(4'hA, v); chk("R12 disabled reads reg", 32'(v), 32'h00300);

    // R9 priority on a shared peripheral line
    clear_log();
    wr(4'h1, 20'h00010); wr(4'h2, 20'h00020); wr(4'h3, 20'd0);
    wr(4'h9, 20'h00030); wr(4'hA, 20'h00040); wr(4'hB, 20'd0);
    wr(4'h0, C_EN | 20'h200); wr(4'h8, C_EN | 20'h200);
    @(negedge clk); req[0] = 1'b1;
    @(negedge clk); req[0] = 1'b0;
    idle(12);
    chk("R9 both served", 32'(wcount), 2);
    chk("R9 ch0 first", 32'(wlog[0]), 32'h00020);
    chk("R9 ch1 second", 32'(wlog[1]), 32'h00040);

    // R10 external pin edges
    clear_log();
    wr(4'h9, 20'h00050); wr(4'hA, 20'h00060); wr(4'hB, 20'd9);
    wr(4'h8, C_EN | C_DINC | 20'h100);
    @(negedge clk); ext[1] = 1'b0; idle(6);
    chk("R10 falling edge", 32'(wcount), 1);
    ext[1] = 1'b1; idle(6);
    chk("R10 rising ignored", 32'(wcount), 1);
    wr(4'h8, C_EN | C_DINC | C_BOTH | 20'h100);
    ext[1] = 1'b0; idle(6);
    ext[1] = 1'b1; idle(6);
    chk("R10 both edges", 32'(wcount), 3);
    @(negedge clk); req[1] = 1'b1; @(negedge clk); req[1] = 1'b0; idle(6);
    chk("R10 other line ignored", 32'(wcount), 3);
    wr(4'h8, 20'h0);

    // R7 / R8 repeat mode
    clear_log();
    wr(4'h1, 20'h00070); wr(4'h2, 20'h00080); wr(4'h3, 20'd1);
    wr(4'h0, C_EN | C_RPT | C_DINC | C_WIDE);
    for (int t = 0; t < 3; t++) begin
      wr(4'h0, C_EN | C_RPT | C_DINC | C_WIDE | C_SW); idle(6);
    end
    chk("R8 one underflow", 32'(irq0_cnt), 1);
    rd(4'h0, v); chk("R7 stays enabled", 32'(v[0]), 1);
    chk("R7 pointer restart", 32'(wlog[2]), 32'h00080);
    wr(4'h0, C_EN | C_RPT | C_DINC | C_WIDE | C_SW); idle(6);
    chk("R8 second underflow", 32'(irq0_cnt), 2);
    wr(4'h0, 20'h0);

    // R11 held request, then dropped by disable
    clear_log();
    wr(4'h1, 20'h00090); wr(4'h2, 20'h000A0); wr(4'h3, 20'd7);
    wr(4'h0, C_EN | C_DINC);
    mem_ready = 1'b0;
    wr(4'h0, C_EN | C_DINC | C_SW); idle(3);
    wr(4'h0, C_EN | C_DINC | C_SW); idle(3);
    mem_ready = 1'b1; idle(10);
    chk("R11 held request served", 32'(wcount), 2);
    mem_ready = 1'b0;
    wr(4'h0, C_EN | C_DINC | C_SW); idle(3);
    wr(4'h0, C_EN | C_DINC | C_SW); idle(1);
    wr(4'h0, C_DINC);
    mem_ready = 1'b1; idle(10);
    chk("R11 disable drops held", 32'(wcount), 3);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule